// File: doc/BRIEF.md
# Two-Level Paged Address Translator

This block turns a 32-bit virtual address into a physical address for 4 KiB pages. The page number is split into two 10-bit indices. The upper index selects a word in an outer table. That word names the page holding an inner table, and the lower index selects the frame word inside that inner table. The physical address is the frame number from the inner word placed above the untouched 12-bit page offset. Each table word carries a presence flag and, in the inner word, read, write and execute permission flags. A request fails with a 2-bit fault code when its outer index is out of range, when either word is not present, or when the access type is not permitted.

An eight-entry, fully associative translation cache is searched on the whole page number before any walk starts. A hit answers without touching memory. A miss performs exactly two reads through a simple request/response memory port, and every walk that succeeds fills one cache slot in round-robin order. The outer table base and its entry count are loaded through a configuration write strobe. Every such write empties the cache. Only one translation is in flight at a time.

Top module: `vaTranslator`

## Requirements
- R1: After reset the stored outer length is 0, so every request completes with fault code 01, a physical address of 0 and no memory reads.
- R2: A walk issues exactly two reads. The first read is at tableBase + 4*va[31:22]. The second is at {outerWord[31:12], va[21:12], 2'b00}. A successful walk returns fault 00 and the physical address {innerWord[31:12], va[11:0]}.
- R3: When va[31:22] is greater than or equal to the configured length, the response is fault 01 with no memory read. An index of exactly length-1 is in range.
- R4: Bit 0 of a table word is the presence flag. If it is clear in the outer word, the response is fault 10 after one read. If it is clear in the inner word, the response is fault 10 after two reads.
- R5: Inner word bits 1, 2 and 3 grant read, write and execute. The access code is 00 for read, 01 for write, 10 for execute, and 11, which is never permitted. A present inner word whose flag for the access is clear gives fault 11.
- R6: A request whose page number matches a cached entry is answered with no memory reads. The physical address equals the one the walk produced, and the permission check uses the cached flags.
- R7: The cache holds 8 entries, replaced in round-robin order. After 9 distinct successful walks, the first page walks again and the second still hits.
- R8: A configuration write empties the cache. A page cached before the write is walked again using the new table base.
- R9: reqReady is low from acceptance until the response. rspValid is a one-cycle pulse. A faulting response carries address 0. A memory request holds its valid and address until memReqReady is seen high.
- R10: A walk that ends in a fault does not fill the cache, so repeating the same request walks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Loads table base and length, and empties the cache |
| cfgBaseIn | input | 32 | Physical byte address of the outer table |
| cfgLenIn | input | 11 | Number of valid outer entries (0 to 1024) |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqVa | input | 32 | Virtual address |
| reqAcc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| rspValid | output | 1 | One-cycle response strobe |
| rspPa | output | 32 | Physical address, 0 on fault |
| rspFault | output | 2 | 00 ok, 01 length, 10 not present, 11 protection |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Byte address of the table word |
| memRspValid | input | 1 | Read data strobe |
| memRspData | input | 32 | Table word read |

## Verification
The bench counts memory reads per request to tell hits from walks. A cache that did not match, did not fill, or filled after a faulting walk would show the wrong read count, even when the address it returned was right. The length boundary is tested at exactly the length and at one below it, which exposes an off-by-one compare as a wrong fault code. Eviction is tested with nine pages, so a replacement order other than round robin evicts the wrong page. A flush test with a new base catches a cache that keeps stale frames. A stalled memory port checks that the read request stays asserted with a stable address.

// File: rtl/vatPkg.sv
package vatPkg;
  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int VPN_W   = 2 * IDX_W;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int LEN_W   = IDX_W + 1;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_LEN     = 2'b01,
    FLT_ABSENT  = 2'b10,
    FLT_PROT    = 2'b11
  } fault_e;

  typedef struct packed {
    logic   capture;
    logic   latchOuter;
    logic   selInner;
    logic   fill;
    logic   loadRsp;
    logic   fromWalk;
    fault_e fault;
  } strobes_t;

  typedef struct packed {
    logic lenFault;
    logic tlbHit;
    logic hitPermOk;
    logic walkValid;
    logic walkPermOk;
  } status_t;

  function automatic logic permits(input logic [2:0] rwx, input logic [1:0] acc);
    case (acc)
      2'b00:   permits = rwx[0];
      2'b01:   permits = rwx[1];
      2'b10:   permits = rwx[2];
      default: permits = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vatDatapath.sv
module vatDatapath
  import vatPkg::*;
#(
  parameter int TlbEntries = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgBaseIn,
  input  logic [LEN_W-1:0]  cfgLenIn,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [1:0]        reqAcc,
  input  logic [ADDR_W-1:0] memRspData,
  input  strobes_t          stb,
  output status_t           sts,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] rspPa,
  output logic [1:0]        rspFault
);
  localparam int PTR_W = (TlbEntries > 1) ? $clog2(TlbEntries) : 1;

  logic [ADDR_W-1:0]  cfgBaseQ;
  logic [LEN_W-1:0]   cfgLenQ;
  logic [ADDR_W-1:0]  vaQ;
  logic [1:0]         accQ;
  logic [FRAME_W-1:0] outerFrameQ;

  logic               tlbVld   [TlbEntries];
  logic [VPN_W-1:0]   tlbVpn   [TlbEntries];
  logic [FRAME_W-1:0] tlbFrame [TlbEntries];
  logic [2:0]         tlbPerm  [TlbEntries];
  logic [PTR_W-1:0]   fillPtr;
  logic [TlbEntries-1:0] matchVec;

  logic [IDX_W-1:0]   outerIdx, innerIdx;
  logic [VPN_W-1:0]   vpnQ;
  logic [FRAME_W-1:0] hitFrame;
  logic [2:0]         hitPerm;
  logic               anyVld;
  logic               unusedRsvd;

  assign outerIdx   = vaQ[ADDR_W-1 -: IDX_W];
  assign innerIdx   = vaQ[OFF_W +: IDX_W];
  assign vpnQ       = vaQ[ADDR_W-1 -: VPN_W];
  assign unusedRsvd = ^memRspData[OFF_W-1:4];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBaseQ <= '0;
      cfgLenQ  <= '0;
    end else if (cfgWe) begin
      cfgBaseQ <= cfgBaseIn;
      cfgLenQ  <= cfgLenIn;
    end
  end

  // request and walk registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ         <= '0;
      accQ        <= '0;
      outerFrameQ <= '0;
    end else begin
      if (stb.capture) begin
        vaQ  <= reqVa;
        accQ <= reqAcc;
      end
      if (stb.latchOuter) outerFrameQ <= memRspData[ADDR_W-1:OFF_W];
    end
  end

  // table word addresses
  always_comb begin
    if (stb.selInner) memReqAddr = {outerFrameQ, innerIdx, 2'b00};
    else              memReqAddr = cfgBaseQ + ADDR_W'({outerIdx, 2'b00});
  end

  // parallel match
  for (genvar i = 0; i < TlbEntries; i++) begin : g_match
    assign matchVec[i] = tlbVld[i] && (tlbVpn[i] == vpnQ);
  end

  always_comb begin
    hitFrame = '0;
    hitPerm  = '0;
    anyVld   = 1'b0;
    for (int i = 0; i < TlbEntries; i++) begin
      if (matchVec[i]) begin
        hitFrame = hitFrame | tlbFrame[i];
        hitPerm  = hitPerm | tlbPerm[i];
      end
      anyVld = anyVld | tlbVld[i];
    end
  end

  // cache storage, flush wins over fill
  always_ff @(posedge clk) begin
    if (!rstN || cfgWe) begin
      fillPtr <= '0;
      for (int i = 0; i < TlbEntries; i++) begin
        tlbVld[i]   <= 1'b0;
        tlbVpn[i]   <= '0;
        tlbFrame[i] <= '0;
        tlbPerm[i]  <= '0;
      end
    end else if (stb.fill) begin
      for (int i = 0; i < TlbEntries; i++) begin
        if (fillPtr == PTR_W'(i)) begin
          tlbVld[i]   <= 1'b1;
          tlbVpn[i]   <= vpnQ;
          tlbFrame[i] <= memRspData[ADDR_W-1:OFF_W];
          tlbPerm[i]  <= memRspData[3:1];
        end
      end
      if (fillPtr == PTR_W'(TlbEntries - 1)) fillPtr <= '0;
      else                                  fillPtr <= fillPtr + 1'b1;
    end
  end

  assign sts.lenFault   = ({1'b0, outerIdx} >= cfgLenQ);
  assign sts.tlbHit     = |matchVec;
  assign sts.hitPermOk  = permits(hitPerm, accQ);
  assign sts.walkValid  = memRspData[0];
  assign sts.walkPermOk = permits(memRspData[3:1], accQ);

  // response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPa    <= '0;
      rspFault <= '0;
    end else if (stb.loadRsp) begin
      rspFault <= stb.fault;
      if (stb.fault != FLT_NONE) rspPa <= '0;
      else if (stb.fromWalk)     rspPa <= {memRspData[ADDR_W-1:OFF_W], vaQ[OFF_W-1:0]};
      else                       rspPa <= {hitFrame, vaQ[OFF_W-1:0]};
    end
  end

  AST_TLB_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> !anyVld); // R8
endmodule

// File: rtl/vatCtrl.sv
module vatCtrl
  import vatPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  output logic     rspValid,
  output logic     memReqValid,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  status_t  sts,
  output strobes_t stb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_OUT_REQ, ST_OUT_WAIT, ST_IN_REQ, ST_IN_WAIT, ST_RESP
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    stb.fault   = FLT_NONE;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          stateNext   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (sts.lenFault) begin
          stb.loadRsp = 1'b1;
          stb.fault   = FLT_LEN;
          stateNext   = ST_RESP;
        end else if (sts.tlbHit) begin
          stb.loadRsp = 1'b1;
          stb.fault   = sts.hitPermOk ? FLT_NONE : FLT_PROT;
          stateNext   = ST_RESP;
        end else begin
          stateNext = ST_OUT_REQ;
        end
      end
      ST_OUT_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_OUT_WAIT;
      end
      ST_OUT_WAIT: begin
        if (memRspValid) begin
          if (!sts.walkValid) begin
            stb.loadRsp = 1'b1;
            stb.fault   = FLT_ABSENT;
            stateNext   = ST_RESP;
          end else begin
            stb.latchOuter = 1'b1;
            stateNext      = ST_IN_REQ;
          end
        end
      end
      ST_IN_REQ: begin
        memReqValid  = 1'b1;
        stb.selInner = 1'b1;
        if (memReqReady) stateNext = ST_IN_WAIT;
      end
      ST_IN_WAIT: begin
        stb.selInner = 1'b1;
        if (memRspValid) begin
          stb.loadRsp  = 1'b1;
          stb.fromWalk = 1'b1;
          stateNext    = ST_RESP;
          if (!sts.walkValid)       stb.fault = FLT_ABSENT;
          else if (!sts.walkPermOk) stb.fault = FLT_PROT;
          else                      stb.fill  = 1'b1;
        end
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid); // R9
  AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && sts.lenFault) |=> !memReqValid); // R3
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> !reqReady); // R9
endmodule

// File: rtl/vaTranslator.sv
module vaTranslator
  import vatPkg::*;
#(
  parameter int TlbEntries = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [31:0] cfgBaseIn,
  input  logic [10:0] cfgLenIn,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVa,
  input  logic [1:0]  reqAcc,
  output logic        rspValid,
  output logic [31:0] rspPa,
  output logic [1:0]  rspFault,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);
  strobes_t stb;
  status_t  sts;

  vatCtrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .sts         (sts),
    .stb         (stb)
  );

  vatDatapath #(.TlbEntries(TlbEntries)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgBaseIn  (cfgBaseIn),
    .cfgLenIn   (cfgLenIn),
    .reqVa      (reqVa),
    .reqAcc     (reqAcc),
    .memRspData (memRspData),
    .stb        (stb),
    .sts        (sts),
    .memReqAddr (memReqAddr),
    .rspPa      (rspPa),
    .rspFault   (rspFault)
  );

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'b00) |-> (rspPa == 32'h0)); // R9
  AST_MEM_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr)); // R9
endmodule

// File: tb/test_vaTranslator.sv
module test_vaTranslator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgBaseIn = '0;
  logic [10:0] cfgLenIn = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic [1:0]  reqAcc = '0;
  logic        rspValid;
  logic [31:0] rspPa;
  logic [1:0]  rspFault;
  logic        memReqValid;
  logic        memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  logic        memStall = 1'b0;
  logic        pendValid = 1'b0;
  logic [31:0] pendAddr = '0;
  int          readCount = 0;
  logic [31:0] rdLog [64];
  logic [31:0] memImg [logic [31:0]];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [31:0] BASE1 = 32'h0010_0000;
  localparam logic [31:0] BASE2 = 32'h0050_0000;

  always #5 clk = ~clk;

  assign memReqReady = !memStall;

  vaTranslator i_vaTranslator (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgBaseIn(cfgBaseIn), .cfgLenIn(cfgLenIn),
    .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa), .reqAcc(reqAcc),
    .rspValid(rspValid), .rspPa(rspPa), .rspFault(rspFault),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // memory model: response two edges after the accepted request
  always @(posedge clk) begin
    memRspValid <= pendValid;
    memRspData  <= memImg.exists(pendAddr) ? memImg[pendAddr] : 32'h0;
    pendValid   <= memReqValid && memReqReady;
    if (memReqValid && memReqReady) begin
      pendAddr <= memReqAddr;
      rdLog[readCount[5:0]] <= memReqAddr;
      readCount <= readCount + 1;
    end
  end

  function automatic logic [31:0] mkVa(input int p1, input int p2, input int off);
    mkVa = {p1[9:0], p2[9:0], off[11:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [31:0] base, input logic [10:0] len);
    @(negedge clk);
    cfgBaseIn = base;
    cfgLenIn  = len;
    cfgWe     = 1'b1;
    @(negedge clk);
    cfgWe     = 1'b0;
  endtask

  task automatic translate(input logic [31:0] va, input logic [1:0] acc,
                           output logic [31:0] pa, output logic [1:0] flt,
                           output int reads, output bit busyOk);
    int r0;
    int n;
    @(negedge clk);
    r0 = readCount;
    reqVa    = va;
    reqAcc   = acc;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    busyOk = 1'b1;
    n = 0;
    while (!rspValid && n < 200) begin
      if (reqReady) busyOk = 1'b0;
      @(negedge clk);
      n++;
    end
    if (reqReady) busyOk = 1'b0;
    pa    = rspPa;
    flt   = rspFault;
    reads = readCount - r0;
    @(negedge clk);
    if (rspValid) busyOk = 1'b0;
  endtask

  task automatic expectXlate(input string tag, input logic [31:0] va, input logic [1:0] acc,
                             input logic [31:0] expPa, input logic [1:0] expFlt, input int expReads);
    logic [31:0] pa;
    logic [1:0]  flt;
    int          reads;
    bit          busyOk;
    translate(va, acc, pa, flt, reads, busyOk);
    check({tag, " fault"}, {30'd0, flt}, {30'd0, expFlt});
    check({tag, " pa"}, pa, expPa);
    check({tag, " reads"}, reads, expReads);
  endtask

  task automatic buildTables();
    memImg[BASE1 + 32'd4] = 32'h0020_0001;
    memImg[BASE1 + 32'd8] = 32'h0030_0000;
    for (int k = 0; k < 32; k++) begin
      if (k != 6) memImg[32'h0020_0000 + k * 4] = ((32'h0AB00 + k) << 12) | 32'hF;
    end
    memImg[32'h0020_0000 + 5 * 4] = (32'h0AB05 << 12) | 32'h3;
    memImg[32'h0020_0000 + 7 * 4] = (32'h0AB07 << 12) | 32'h9;
    memImg[BASE2 + 32'd4] = 32'h0040_0001;
    memImg[32'h0040_0000 + 12 * 4] = (32'h55555 << 12) | 32'hF;
  endtask

  task automatic tReset();
    check("R1 reqReady after reset", {31'd0, reqReady}, 32'd1);
    check("R1 rspValid after reset", {31'd0, rspValid}, 32'd0);
    expectXlate("R1 zero length", mkVa(0, 3, 12'h010), 2'b00, 32'h0, 2'b01, 0);
  endtask

  task automatic tWalk();
    int r0;
    cfgWrite(BASE1, 11'd16);
    r0 = readCount;
    expectXlate("R2 walk", mkVa(1, 3, 12'h123), 2'b00, 32'h0AB0_3123, 2'b00, 2);
    check("R2 outer address", rdLog[r0[5:0]], 32'h0010_0004);
    check("R2 inner address", rdLog[(r0 + 1) & 63], 32'h0020_000C);
  endtask

  task automatic tHit();
    expectXlate("R6 hit write", mkVa(1, 3, 12'hFFF), 2'b01, 32'h0AB0_3FFF, 2'b00, 0);
    expectXlate("R6 hit exec", mkVa(1, 3, 12'h000), 2'b10, 32'h0AB0_3000, 2'b00, 0);
  endtask

  task automatic tLength();
    expectXlate("R3 index equals length", mkVa(16, 0, 0), 2'b00, 32'h0, 2'b01, 0);
    expectXlate("R3 index far beyond", mkVa(1023, 0, 0), 2'b00, 32'h0, 2'b01, 0);
    expectXlate("R3 index length-1 in range", mkVa(15, 0, 0), 2'b00, 32'h0, 2'b10, 1);
  endtask

  task automatic tAbsent();
    expectXlate("R4 outer absent", mkVa(2, 0, 0), 2'b00, 32'h0, 2'b10, 1);
    expectXlate("R4 inner absent", mkVa(1, 6, 0), 2'b00, 32'h0, 2'b10, 2);
  endtask

  task automatic tPerm();
    expectXlate("R5 read allowed", mkVa(1, 5, 12'h044), 2'b00, 32'h0AB0_5044, 2'b00, 2);
    expectXlate("R5 R6 write denied on hit", mkVa(1, 5, 12'h044), 2'b01, 32'h0, 2'b11, 0);
    expectXlate("R5 R6 exec denied on hit", mkVa(1, 5, 12'h044), 2'b10, 32'h0, 2'b11, 0);
    expectXlate("R5 reserved code denied", mkVa(1, 3, 12'h001), 2'b11, 32'h0, 2'b11, 0);
  endtask

  task automatic tNoFill();
    expectXlate("R10 R5 walk prot fault", mkVa(1, 7, 0), 2'b00, 32'h0, 2'b11, 2);
    expectXlate("R10 repeat walks again", mkVa(1, 7, 0), 2'b00, 32'h0, 2'b11, 2);
    expectXlate("R10 exec allowed", mkVa(1, 7, 12'h00C), 2'b10, 32'h0AB0_700C, 2'b00, 2);
  endtask

  task automatic tRoundRobin();
    cfgWrite(BASE1, 11'd16);
    for (int k = 10; k <= 18; k++)
      expectXlate("R7 fill", mkVa(1, k, 0), 2'b00, (32'h0AB00 + k) << 12, 2'b00, 2);
    expectXlate("R7 second page still hits", mkVa(1, 11, 0), 2'b00, 32'h0AB0_B000, 2'b00, 0);
    expectXlate("R7 first page evicted", mkVa(1, 10, 0), 2'b00, 32'h0AB0_A000, 2'b00, 2);
  endtask

  task automatic tFlush();
    expectXlate("R8 cached before flush", mkVa(1, 12, 12'h0AA), 2'b00, 32'h0AB0_C0AA, 2'b00, 0);
    cfgWrite(BASE2, 11'd4);
    expectXlate("R8 rewalk after flush", mkVa(1, 12, 12'h0AA), 2'b00, 32'h5555_50AA, 2'b00, 2);
  endtask

  task automatic tStall();
    logic [31:0] addr0;
    bit          held;
    int          n;
    cfgWrite(BASE1, 11'd16);
    @(negedge clk);
    memStall = 1'b1;
    reqVa    = mkVa(1, 20, 12'h321);
    reqAcc   = 2'b00;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    addr0 = memReqAddr;
    held  = memReqValid;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!memReqValid || memReqAddr !== addr0) held = 1'b0;
    end
    check("R9 request held while stalled", {31'd0, held}, 32'd1);
    check("R9 stalled address", addr0, 32'h0010_0004);
    memStall = 1'b0;
    n = 0;
    while (!rspValid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check("R9 stalled walk pa", rspPa, 32'h0AB1_4321);
    @(negedge clk);
    check("R9 rspValid is a pulse", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic tBusy();
    logic [31:0] pa;
    logic [1:0]  flt;
    int          reads;
    bit          busyOk;
    translate(mkVa(1, 21, 0), 2'b00, pa, flt, reads, busyOk);
    check("R9 not ready while busy, walk", {31'd0, busyOk}, 32'd1);
    translate(mkVa(1, 21, 0), 2'b00, pa, flt, reads, busyOk);
    check("R9 not ready while busy, hit", {31'd0, busyOk}, 32'd1);
    check("R9 hit pa", pa, 32'h0AB1_5000);
  endtask

  initial begin
    buildTables();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWalk();
    tHit();
    tLength();
    tAbsent();
    tPerm();
    tNoFill();
    tRoundRobin();
    tFlush();
    tStall();
    tBusy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule